// File: doc/BRIEF.md
# Approximate Power-to-Decibel Converter

This block turns one complex sample (signed in-phase and quadrature parts) into an approximate power level in decibels, with no square root and no full logarithm table. Squaring both parts and adding them gives the power, and 10·log10 of the power equals 20·log10 of the magnitude. The base-2 logarithm of that power splits into an integer part and a fraction. The integer part is the position of the leading one, and each position is worth about 3 dB. The fraction comes from the few bits just below the leading one, which select an entry in a small correction table.

Samples enter with a valid strobe and may arrive on every clock. Each result leaves a fixed three cycles later with its own valid strobe. The three pipeline stages are square-and-sum, leading-one normalization, and table lookup with final addition. The output is unsigned fixed point in sixteenths of a dB. An all-zero sample cannot be expressed as a logarithm, so it gives code 0 and raises a separate zero flag.

Top module: `pwrdb_conv`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid`, `out_db` and `out_zero` are all 0.
- R2: A sample taken at a rising edge with `in_valid` high produces `out_valid` high after the third rising edge, counting the sampling edge as the first. `out_valid` is low in every other cycle for which no such sample exists.
- R3: For a nonzero sample, let S = I²+Q² (32-bit unsigned), let p be the bit position of the leading one of S (0 to 31), and let k be the 4 bits directly below that one, with missing low bits taken as 0. Then `out_db` = 48·p + T(k), where 48 is 3.0103 dB rounded to sixteenths.
- R4: Correction entry T(k) for k = 0..15 equals 160·log10(1 + k/16) rounded to the nearest integer, so its values lie between 0 and 46.
- R5: An all-zero sample gives `out_db` = 0 with `out_zero` = 1. Every nonzero sample gives `out_zero` = 0, including S = 1, whose code is also 0.
- R6: The largest power, I = Q = -32768 (S = 2^31), gives p = 31, k = 0 and `out_db` = 1488 with no overflow. The output never exceeds 1534.
- R7: The result depends only on S. Negating either part or swapping the two parts leaves `out_db` unchanged.
- R8: Samples presented on consecutive cycles each produce their own correct result on consecutive cycles, in order.
- R9: When no result is being delivered, `out_db` and `out_zero` keep the values of the most recent result.
- R10: For any nonzero sample, the exact value 160·log10(S) minus `out_db` lies strictly between -1 and 12 sixteenths of a dB, that is, below 0.75 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 16 | In-phase part, two's complement |
| in_q | input | 16 | Quadrature part, two's complement |
| out_valid | output | 1 | Result strobe, three cycles after the sample |
| out_db | output | 11 | Power level in units of 1/16 dB |
| out_zero | output | 1 | Result belongs to an all-zero sample |

## Verification
Hand-picked samples test the parts of the result separately. A power of 1 gives code 0 without the zero flag. A power of 25 has a leading one at bit 4 with index 9, which checks the bit weight and the table together. The full-scale negative pair reaches position 31. The all-zero sample checks the flag. Sign-flipped and swapped copies of one sample show that only the power matters. A long back-to-back stream starts with small sums that walk through every table index and then moves to spread-out large values. Each result in the stream is compared with the formula and also with the true logarithm, which separates a wrong table entry or weight from a wrong shift or index.

// File: rtl/pwrdb_pkg.sv
package pwrdb_pkg;

   // fractional bits of the output code (1/16 dB)
   localparam int FRAC_BITS = 4;
   // 3.0103 dB per power bit, in 1/16 dB, rounded
   localparam int STEP_Q    = 48;
   // width of one correction entry
   localparam int CORR_W    = 6;

   typedef logic [CORR_W-1:0] corr_t;

   // 16-entry correction: round(160*log10(1+k/16))
   function automatic corr_t corr_fine(input logic [3:0] k);
      corr_t v;
      case (k)
         4'd0:    v = 6'd0;
         4'd1:    v = 6'd4;
         4'd2:    v = 6'd8;
         4'd3:    v = 6'd12;
         4'd4:    v = 6'd16;
         4'd5:    v = 6'd19;
         4'd6:    v = 6'd22;
         4'd7:    v = 6'd25;
         4'd8:    v = 6'd28;
         4'd9:    v = 6'd31;
         4'd10:   v = 6'd34;
         4'd11:   v = 6'd36;
         4'd12:   v = 6'd39;
         4'd13:   v = 6'd41;
         4'd14:   v = 6'd44;
         default: v = 6'd46;
      endcase
      return v;
   endfunction

   // 8-entry correction: round(160*log10(1+k/8))
   function automatic corr_t corr_coarse(input logic [2:0] k);
      corr_t v;
      case (k)
         3'd0:    v = 6'd0;
         3'd1:    v = 6'd8;
         3'd2:    v = 6'd16;
         3'd3:    v = 6'd22;
         3'd4:    v = 6'd28;
         3'd5:    v = 6'd34;
         3'd6:    v = 6'd39;
         default: v = 6'd44;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pwrdb_square.sv
module pwrdb_square #(
   parameter int IQ_W  = 16,
   parameter int SUM_W = 2*IQ_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic signed [IQ_W-1:0]  i_i,
   input  logic signed [IQ_W-1:0]  q_i,
   output logic                    vld_o,
   output logic [SUM_W-1:0]        sum_o
);

   localparam int PROD_W = 2*IQ_W;

   logic signed [PROD_W-1:0] ii_c;
   logic signed [PROD_W-1:0] qq_c;
   logic [SUM_W-1:0]         sum_c;

   generate
      if (SUM_W != PROD_W) begin : g_bad_sum
         $error("pwrdb_square: SUM_W must be twice IQ_W");
      end
   endgenerate

   always_comb begin
      ii_c  = PROD_W'(i_i) * PROD_W'(i_i);
      qq_c  = PROD_W'(q_i) * PROD_W'(q_i);
      sum_c = SUM_W'($unsigned(ii_c)) + SUM_W'($unsigned(qq_c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         sum_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) sum_o <= sum_c;
      end
   end

   // the sum of two squares never exceeds 2^(SUM_W-1)
   AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (sum_o <= (SUM_W'(1) << (SUM_W-1)))); // R6

endmodule

// File: rtl/pwrdb_normalize.sv
module pwrdb_normalize #(
   parameter int SUM_W      = 32,
   parameter int IDX_W      = 4,
   parameter int NORM_STYLE = 1,
   parameter int POS_W      = $clog2(SUM_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [SUM_W-1:0]  sum_i,
   output logic              vld_o,
   output logic              zero_o,
   output logic [POS_W-1:0]  pos_o,
   output logic [IDX_W-1:0]  idx_o
);

   logic [POS_W-1:0] pos_c;
   logic [SUM_W-1:0] norm_c;
   logic             zero_c;

   generate
      if (IDX_W > SUM_W-1) begin : g_bad_idx
         $error("pwrdb_normalize: IDX_W too wide for SUM_W");
      end
      if (NORM_STYLE == 0) begin : g_scan
         // priority scan from the bottom, last hit wins
         always_comb begin
            pos_c = '0;
            for (int j = 0; j < SUM_W; j++) begin
               if (sum_i[j]) pos_c = POS_W'(j);
            end
            norm_c = sum_i << (POS_W'(SUM_W-1) - pos_c);
         end
      end else begin : g_halve
         if (SUM_W != (1 << POS_W)) begin : g_bad_pow
            $error("pwrdb_normalize: halving style needs SUM_W a power of two");
         end
         logic [SUM_W-1:0] xs [0:POS_W];
         logic [POS_W-1:0] lz;
         assign xs[0] = sum_i;
         for (genvar g = 0; g < POS_W; g++) begin : g_stage
            localparam int SH = 1 << (POS_W-1-g);
            logic hit;
            assign hit = (xs[g][SUM_W-1 -: SH] == '0);
            assign xs[g+1] = hit ? (xs[g] << SH) : xs[g];
            assign lz[POS_W-1-g] = hit;
         end
         assign norm_c = xs[POS_W];
         assign pos_c  = ~lz;
      end
   endgenerate

   assign zero_c = (sum_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         zero_o <= 1'b0;
         pos_o  <= '0;
         idx_o  <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            zero_o <= zero_c;
            pos_o  <= zero_c ? '0 : pos_c;
            idx_o  <= zero_c ? '0 : norm_c[SUM_W-2 -: IDX_W];
         end
      end
   end

   // the found position really holds the leading one of the sum
   AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !zero_c) |-> ((sum_i >> pos_c) == SUM_W'(1))); // R3

   // normalisation always brings a one to the top bit
   AST_NORM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !zero_c) |-> norm_c[SUM_W-1]); // R3

endmodule

// File: rtl/pwrdb_lut_add.sv
module pwrdb_lut_add
   import pwrdb_pkg::*;
#(
   parameter int POS_W = 5,
   parameter int IDX_W = 4,
   parameter int DB_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic              zero_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              vld_o,
   output logic              zero_o,
   output logic [DB_W-1:0]   db_o
);

   corr_t            corr_c;
   logic [DB_W-1:0]  db_c;

   generate
      if (IDX_W == 4) begin : g_fine
         assign corr_c = corr_fine(idx_i);
      end else if (IDX_W == 3) begin : g_coarse
         assign corr_c = corr_coarse(idx_i);
      end else begin : g_bad_idx
         assign corr_c = '0;
         $error("pwrdb_lut_add: IDX_W must be 3 or 4");
      end
   endgenerate

   always_comb begin
      if (zero_i) db_c = '0;
      else        db_c = DB_W'(pos_i) * DB_W'(STEP_Q) + DB_W'(corr_c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         zero_o <= 1'b0;
         db_o   <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            zero_o <= zero_i;
            db_o   <= db_c;
         end
      end
   end

   // outputs only move when a result is delivered
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> ($stable(db_o) && $stable(zero_o))); // R9

endmodule

// File: rtl/pwrdb_conv.sv
module pwrdb_conv
   import pwrdb_pkg::*;
#(
   parameter int IQ_W       = 16,
   parameter int IDX_W      = 4,
   parameter int NORM_STYLE = 1,
   parameter int SUM_W      = 2*IQ_W,
   parameter int POS_W      = $clog2(SUM_W),
   parameter int DB_MAX     = (SUM_W-1)*STEP_Q + 46,
   parameter int DB_W       = $clog2(DB_MAX+1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IQ_W-1:0] in_i,
   input  logic signed [IQ_W-1:0] in_q,
   output logic                   out_valid,
   output logic [DB_W-1:0]        out_db,
   output logic                   out_zero
);

   logic              s1_vld;
   logic [SUM_W-1:0]  s1_sum;
   logic              s2_vld;
   logic              s2_zero;
   logic [POS_W-1:0]  s2_pos;
   logic [IDX_W-1:0]  s2_idx;

   generate
      if (IQ_W < 4) begin : g_bad_iq
         $error("pwrdb_conv: IQ_W must be at least 4");
      end
      if (NORM_STYLE != 0 && NORM_STYLE != 1) begin : g_bad_style
         $error("pwrdb_conv: NORM_STYLE must be 0 or 1");
      end
   endgenerate

   pwrdb_square #(
      .IQ_W  (IQ_W),
      .SUM_W (SUM_W)
   ) u_square (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .i_i   (in_i),
      .q_i   (in_q),
      .vld_o (s1_vld),
      .sum_o (s1_sum)
   );

   pwrdb_normalize #(
      .SUM_W      (SUM_W),
      .IDX_W      (IDX_W),
      .NORM_STYLE (NORM_STYLE),
      .POS_W      (POS_W)
   ) u_norm (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s1_vld),
      .sum_i  (s1_sum),
      .vld_o  (s2_vld),
      .zero_o (s2_zero),
      .pos_o  (s2_pos),
      .idx_o  (s2_idx)
   );

   pwrdb_lut_add #(
      .POS_W (POS_W),
      .IDX_W (IDX_W),
      .DB_W  (DB_W)
   ) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s2_vld),
      .zero_i (s2_zero),
      .pos_i  (s2_pos),
      .idx_i  (s2_idx),
      .vld_o  (out_valid),
      .zero_o (out_zero),
      .db_o   (out_db)
   );

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 out_valid); // R2

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##3 !out_valid); // R2

   AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      out_zero |-> (out_db == '0)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_db <= DB_W'(DB_MAX))); // R6

endmodule

// File: tb/pwrdb_conv_test.sv
module pwrdb_conv_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_i = '0;
   logic signed [15:0] in_q = '0;
   logic               out_valid;
   logic [10:0]        out_db;
   logic               out_zero;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   localparam int NSTR = 1200;
   int  s_db  [0:NSTR-1];
   bit  s_z   [0:NSTR-1];
   real s_ex  [0:NSTR-1];

   always #10 clk = ~clk;

   pwrdb_conv uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_db    (out_db),
      .out_zero  (out_zero)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // expected code from the requirement formulas
   function automatic int ref_db(input int i, input int q, output bit z, output real exact);
      longint s;
      int p;
      int k;
      s = longint'(i)*i + longint'(q)*q;
      exact = 0.0;
      if (s == 0) begin
         z = 1'b1;
         return 0;
      end
      z = 1'b0;
      p = 0;
      for (int b = 0; b < 32; b++) if (((s >> b) & 1) == 1) p = b;
      if (p >= 4) k = int'((s >> (p-4)) & 15);
      else        k = int'((s << (4-p)) & 15);
      exact = 160.0 * $log10(real'(s));
      return p*48 + $rtoi(160.0*$log10(1.0 + real'(k)/16.0) + 0.5);
   endfunction

   task automatic t_reset();
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      check(out_db == 11'd0,   "R1 db in reset", int'(out_db), 0);
      check(out_zero == 1'b0,  "R1 zero in reset", int'(out_zero), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      check(out_db == 11'd0,   "R1 db after reset", int'(out_db), 0);
   endtask

   // one isolated sample: latency, value, flag, then hold
   task automatic t_single(input int i, input int q, input string tag);
      bit  z;
      real ex;
      int  e;
      e = ref_db(i, q, z, ex);
      @(negedge clk);
      in_i = 16'(i); in_q = 16'(q); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, {"R2 early valid ", tag}, int'(out_valid), 0);
      @(negedge clk);
      check(out_valid == 1'b1, {"R2 valid at latency ", tag}, int'(out_valid), 1);
      check(int'(out_db) == e, {"R3 code ", tag}, int'(out_db), e);
      check(out_zero == z,     {"R5 zero flag ", tag}, int'(out_zero), int'(z));
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, {"R2 single pulse ", tag}, int'(out_valid), 0);
      check(int'(out_db) == e, {"R9 code held ", tag}, int'(out_db), e);
      check(out_zero == z,     {"R9 flag held ", tag}, int'(out_zero), int'(z));
   endtask

   task automatic t_fixed();
      t_single(1, 0, "S=1");
      check(int'(out_db) == 0 && !out_zero, "R5 S=1 code 0 no flag", int'(out_db), 0);
      t_single(3, 4, "S=25");
      check(int'(out_db) == 223, "R3 S=25 gives 4*48+31", int'(out_db), 223);
      t_single(0, 0, "zero");
      check(out_zero == 1'b1 && out_db == 11'd0, "R5 zero sample", int'(out_db), 0);
      t_single(-32768, -32768, "full scale");
      check(int'(out_db) == 1488, "R6 full scale 1488", int'(out_db), 1488);
      t_single(32767, 0, "max I");
      t_single(100, -200, "mixed");
   endtask

   task automatic t_sym();
      int a;
      t_single(1234, -567, "base");
      a = int'(out_db);
      t_single(-1234, -567, "neg I");
      check(int'(out_db) == a, "R7 negate I", int'(out_db), a);
      t_single(1234, 567, "neg Q");
      check(int'(out_db) == a, "R7 negate Q", int'(out_db), a);
      t_single(-567, 1234, "swap");
      check(int'(out_db) == a, "R7 swap parts", int'(out_db), a);
   endtask

   // back-to-back stream, covering every table index on small sums
   task automatic t_stream();
      int ii [0:NSTR-1];
      int qq [0:NSTR-1];
      for (int n = 0; n < NSTR; n++) begin
         if (n < 80) begin
            ii[n] = n;
            qq[n] = n / 3;
         end else begin
            ii[n] = ((n*733) % 65536) - 32768;
            qq[n] = ((n*1217 + 999) % 65536) - 32768;
         end
         s_db[n] = ref_db(ii[n], qq[n], s_z[n], s_ex[n]);
      end
      for (int n = 0; n < NSTR + 3; n++) begin
         @(negedge clk);
         if (n >= 3) begin
            int m;
            real err;
            m = n - 3;
            check(out_valid == 1'b1, "R8 stream valid", int'(out_valid), 1);
            check(int'(out_db) == s_db[m], "R4 R8 stream code", int'(out_db), s_db[m]);
            check(out_zero == s_z[m], "R5 stream flag", int'(out_zero), int'(s_z[m]));
            if (!s_z[m]) begin
               err = s_ex[m] - real'(out_db);
               check(err > -1.0 && err < 12.0, "R10 accuracy", int'(out_db), $rtoi(s_ex[m]));
            end
         end
         if (n < NSTR) begin
            in_i = 16'(ii[n]); in_q = 16'(qq[n]); in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      check(out_valid == 1'b0, "R2 stream end", int'(out_valid), 0);
   endtask

   initial begin
      t_reset();
      t_fixed();
      t_sym();
      t_stream();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule